// File: doc/BRIEF.md
# Transparent Serial Receiver with Overrun and Carrier-Loss Handling

This block is the receive half of a bit-transparent serial channel. Serial bits arrive one per strobe. While the receiver is hunting it throws them away. Once a sync-found pulse arrives while carrier is present, it packs the bits that follow into bytes, most significant bit first. Each complete byte goes into a small internal FIFO. A downstream consumer drains the FIFO through a read port. A transfer-request output tells that consumer when a byte (byte mode) or a four-byte word (word mode) is waiting.

Two faults close the current buffer:

- **Overrun.** A byte completes while the FIFO is full and nothing is being read in that cycle. The new byte replaces the most recently stored entry, and that older byte is lost. The overrun status bit is set, and the receiver falls straight back to hunting.
- **Carrier loss.** Carrier drops in the middle of a message. Reception stops at once and any partial byte is discarded. This fault outranks every other, so only the carrier status bit is reported.

Either fault sets a sticky receive event, which software clears by writing one. The interrupt is that event gated by an enable bit.

Top module: `tsr_rx_top`

## Requirements
- R1: In hunt state, bits are discarded. A `sync_hit` pulse seen while `carrier_ok` is 1 starts reception. The bit strobed in that same cycle is not assembled, and assembly begins with the next strobed bit.
- R2: During reception, every 8 strobed bits form one byte. The first bit received becomes bit 7. Bytes are read out of the FIFO in arrival order. `rd_data` shows the oldest entry, and `rd_en` removes it.
- R3: `xfer_req` is 1 when the FIFO holds at least 1 byte while `word_mode`=0, or at least 4 bytes while `word_mode`=1.
- R4: When a byte completes with the FIFO full (DEPTH entries, default 4) and `rd_en`=0, the byte is written over the newest stored entry. The older entries are kept, and the level stays at DEPTH.
- R5: An overrun sets `st_ov` and `st_closed` and sets `rx_evt`, one clock after the completing bit is sampled.
- R6: After an overrun the receiver is back in hunt state. Further bits change nothing until a new sync is accepted.
- R7: If `carrier_ok` is 0 during reception, then in the next cycle `st_cd` and `st_closed` are set, `rx_evt` is set, and the receiver is hunting. Any partial byte is discarded.
- R8: If carrier is lost in the cycle that would complete a byte, the byte is not stored and only `st_cd` is set. `st_ov` stays 0 even when the FIFO is full.
- R9: `rx_evt` stays set until a cycle with `evt_clr`=1. A new event in that same cycle wins over the clear. `irq` equals `rx_evt` AND `irq_en`.
- R10: Accepting a new sync clears `st_ov`, `st_cd` and `st_closed`. It leaves the FIFO contents untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_valid | input | 1 | Strobe: `ser_bit` carries a bit this cycle |
| ser_bit | input | 1 | Serial data bit |
| carrier_ok | input | 1 | Carrier detect, 1 = carrier present |
| sync_hit | input | 1 | Pulse from the sync matcher: pattern found |
| word_mode | input | 1 | 0 = request per byte, 1 = request per 4 bytes |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| rd_data | output | 8 | Oldest FIFO entry |
| fifo_level | output | 3 | Number of stored bytes |
| xfer_req | output | 1 | Downstream transfer request |
| st_ov | output | 1 | Buffer status: closed by overrun |
| st_cd | output | 1 | Buffer status: closed by carrier loss |
| st_closed | output | 1 | Buffer status: buffer closed |
| evt_clr | input | 1 | Write-one-to-clear for `rx_evt` |
| irq_en | input | 1 | Interrupt mask, 1 = enabled |
| rx_evt | output | 1 | Sticky receive event |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest case to reach from the ports is carrier loss landing on exactly the bit that would complete a byte, while the FIFO is already full. In that cycle an overrun and a carrier fault compete, and only the carrier fault may show. The stimulus first fills the FIFO with four bytes and sends seven bits of a fifth. It then drops `carrier_ok` in the same cycle as the eighth strobed bit. The bench then checks that `st_ov` stays clear and that the newest stored entry still holds the fourth byte.

// File: rtl/tsr_pkg.sv
// Package: shared types and constants for the transparent serial receiver.
package tsr_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned WORD_BYTES = 4;

    typedef enum logic {
        RX_HUNT = 1'b0,
        RX_RECV = 1'b1
    } rx_state_t;
endpackage

// File: rtl/tsr_deser.sv
// Serial-to-parallel assembler.
// Shifts strobed bits in MSB first. It raises `done` combinationally in
// the cycle the last bit of a byte is strobed, with the full byte on `data`.
// Assumes the controller holds `clr` high whenever reception is not active.
module tsr_deser #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic         done,
    output logic [W-1:0] data
);
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    // Byte boundary and the byte formed with the current bit.
    always_comb begin
        done = en && (cnt_q == LAST);
        data = {sh_q[W-2:0], din};
    end

    // Shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (en) begin
            sh_q  <= data;
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end

    // Counter never leaves the byte range.
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/tsr_fifo.sv
// Receive FIFO with overwrite-on-overrun.
// A write into a full FIFO with no pop in the same cycle replaces the
// newest entry. In that case `overwrote` is high for the cycle.
// A pop of an empty FIFO is ignored.
// DEPTH must be a power of two.
module tsr_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [W-1:0]                wdata,
    input  logic                        rd,
    output logic [W-1:0]                rdata,
    output logic [$clog2(DEPTH+1)-1:0]  level,
    output logic                        overwrote
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [LW-1:0] lvl_q;
    logic          full, pop, push;
    logic [AW-1:0] wslot;

    // Decode push, pop, overwrite and the target slot.
    always_comb begin
        full      = (lvl_q == FULL_LVL);
        pop       = rd && (lvl_q != '0);
        overwrote = wr && full && !rd;
        push      = wr && !overwrote;
        wslot     = overwrote ? (wp_q - 1'b1) : wp_q;
        rdata     = mem[rp_q];
        level     = lvl_q;
    end

    // Storage array (no reset needed).
    always_ff @(posedge clk) begin
        if (wr) mem[wslot] <= wdata;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            case ({push, pop})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    initial assert ((1 << AW) == DEPTH);

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= FULL_LVL);
    assert_overwrite_keeps_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overwrote |=> (lvl_q == FULL_LVL));
endmodule

// File: rtl/tsr_ctrl.sv
// Receive controller.
// Holds the hunt/receive state and the buffer status bits, and the sticky
// event. Carrier loss is checked before the overrun indication from the
// FIFO. Because a byte is only assembled while carrier is present, the two
// can never both close the same buffer.
module tsr_ctrl
    import tsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ser_valid,
    input  logic      carrier_ok,
    input  logic      sync_hit,
    input  logic      byte_done,
    input  logic      overwrote,
    input  logic      evt_clr,
    output rx_state_t state,
    output logic      deser_clr,
    output logic      deser_en,
    output logic      push,
    output logic      st_ov,
    output logic      st_cd,
    output logic      st_closed,
    output logic      rx_evt
);
    rx_state_t st_q;
    logic      cd_loss, accept_sync, close_any;

    // Gating of assembly and detection of closing conditions.
    always_comb begin
        deser_clr   = (st_q != RX_RECV);
        deser_en    = (st_q == RX_RECV) && ser_valid && carrier_ok;
        push        = byte_done;
        cd_loss     = (st_q == RX_RECV) && !carrier_ok;
        accept_sync = (st_q == RX_HUNT) && sync_hit && carrier_ok;
        close_any   = cd_loss || overwrote;
        state       = st_q;
    end

    // State and buffer status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= RX_HUNT;
            st_ov     <= 1'b0;
            st_cd     <= 1'b0;
            st_closed <= 1'b0;
        end else if (accept_sync) begin
            st_q      <= RX_RECV;
            st_ov     <= 1'b0;
            st_cd     <= 1'b0;
            st_closed <= 1'b0;
        end else if (cd_loss) begin
            st_q      <= RX_HUNT;
            st_cd     <= 1'b1;
            st_closed <= 1'b1;
        end else if (overwrote) begin
            st_q      <= RX_HUNT;
            st_ov     <= 1'b1;
            st_closed <= 1'b1;
        end
    end

    // Sticky receive event: setting wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_evt <= 1'b0;
        else if (close_any) rx_evt <= 1'b1;
        else if (evt_clr)   rx_evt <= 1'b0;
    end

    assert_cd_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_cd && st_ov));
    assert_cd_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_RECV && !carrier_ok) |=> (st_q == RX_HUNT && st_cd && st_closed));
    assert_ov_hunt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overwrote |=> (st_q == RX_HUNT && st_ov));
    assert_no_push_hunt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_HUNT) |-> !push);
    assert_evt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && !evt_clr) |=> rx_evt);
endmodule

// File: rtl/tsr_rx_top.sv
// Top level of the transparent serial receiver.
// Wires the assembler, the FIFO and the controller together, and derives
// the transfer request and the interrupt. Assumes single-cycle `sync_hit`
// pulses from an external pattern matcher.
module tsr_rx_top
    import tsr_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ser_valid,
    input  logic                        ser_bit,
    input  logic                        carrier_ok,
    input  logic                        sync_hit,
    input  logic                        word_mode,
    input  logic                        rd_en,
    output logic [BYTE_W-1:0]           rd_data,
    output logic [$clog2(DEPTH+1)-1:0]  fifo_level,
    output logic                        xfer_req,
    output logic                        st_ov,
    output logic                        st_cd,
    output logic                        st_closed,
    input  logic                        evt_clr,
    input  logic                        irq_en,
    output logic                        rx_evt,
    output logic                        irq
);
    localparam int unsigned LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] WORD_LVL = LW'(WORD_BYTES);

    rx_state_t         state;
    logic              deser_clr, deser_en, byte_done, push, overwrote;
    logic [BYTE_W-1:0] byte_val;

    tsr_deser #(.W(BYTE_W)) u_deser (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (deser_clr),
        .en    (deser_en),
        .din   (ser_bit),
        .done  (byte_done),
        .data  (byte_val)
    );

    tsr_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (push),
        .wdata     (byte_val),
        .rd        (rd_en),
        .rdata     (rd_data),
        .level     (fifo_level),
        .overwrote (overwrote)
    );

    tsr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_valid  (ser_valid),
        .carrier_ok (carrier_ok),
        .sync_hit   (sync_hit),
        .byte_done  (byte_done),
        .overwrote  (overwrote),
        .evt_clr    (evt_clr),
        .state      (state),
        .deser_clr  (deser_clr),
        .deser_en   (deser_en),
        .push       (push),
        .st_ov      (st_ov),
        .st_cd      (st_cd),
        .st_closed  (st_closed),
        .rx_evt     (rx_evt)
    );

    // Transfer request threshold and masked interrupt.
    always_comb begin
        xfer_req = word_mode ? (fifo_level >= WORD_LVL) : (fifo_level != '0);
        irq      = rx_evt && irq_en;
    end

    initial assert (DEPTH >= WORD_BYTES);

    assert_closed_with_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_closed) |-> (st_ov || st_cd) && rx_evt);
    assert_xfer_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_mode && xfer_req) |-> (fifo_level >= WORD_LVL));
endmodule

// File: tb/sim_tsr_rx_top.sv
module sim_tsr_rx_top;
    logic       clk = 1'b0;
    logic       rst_n, ser_valid, ser_bit, carrier_ok, sync_hit, word_mode, rd_en;
    logic       evt_clr, irq_en;
    logic [7:0] rd_data;
    logic [2:0] fifo_level;
    logic       xfer_req, st_ov, st_cd, st_closed, rx_evt, irq;
    int         n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    tsr_rx_top #(.DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_bit(ser_bit),
        .carrier_ok(carrier_ok), .sync_hit(sync_hit), .word_mode(word_mode),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_level(fifo_level),
        .xfer_req(xfer_req), .st_ov(st_ov), .st_cd(st_cd), .st_closed(st_closed),
        .evt_clr(evt_clr), .irq_en(irq_en), .rx_evt(rx_evt), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ser_valid = 1'b0; ser_bit = 1'b0; carrier_ok = 1'b1;
        sync_hit = 1'b0; word_mode = 1'b0; rd_en = 1'b0; evt_clr = 1'b0; irq_en = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_valid = 1'b1; ser_bit = b;
        @(negedge clk);
        ser_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic do_sync();
        sync_hit = 1'b1;
        @(negedge clk);
        sync_hit = 1'b0;
    endtask

    task automatic pop_check(input string req, input logic [7:0] exp);
        check(req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R9 reset evt", rx_evt, 0);
        check("R5 reset closed", {st_ov, st_cd, st_closed}, 0);
        check("R3 reset req", {xfer_req, fifo_level}, 0);
    endtask

    task automatic t_hunt();
        do_reset();
        send_byte(8'hFF); send_byte(8'h00);
        check("R1 hunt discards", fifo_level, 0);
        // A bit strobed with the sync pulse must not be assembled.
        ser_valid = 1'b1; ser_bit = 1'b1; sync_hit = 1'b1;
        @(negedge clk);
        ser_valid = 1'b0; sync_hit = 1'b0;
        send_byte(8'h5A);
        check("R1 sync bit ignored level", fifo_level, 1);
        check("R1 sync bit ignored data", rd_data, 8'h5A);
    endtask

    task automatic t_order();
        do_reset();
        do_sync();
        send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h81);
        check("R2 level", fifo_level, 3);
        pop_check("R2 first", 8'hA5);
        pop_check("R2 second", 8'h3C);
        pop_check("R2 third", 8'h81);
        check("R2 empty", fifo_level, 0);
    endtask

    task automatic t_xfer();
        do_reset();
        do_sync();
        check("R3 byte none", xfer_req, 0);
        send_byte(8'h11);
        check("R3 byte one", xfer_req, 1);
        word_mode = 1'b1; #1;
        check("R3 word one", xfer_req, 0);
        @(negedge clk);
        send_byte(8'h22); send_byte(8'h33);
        check("R3 word three", xfer_req, 0);
        send_byte(8'h44);
        check("R3 word four", xfer_req, 1);
    endtask

    task automatic t_overrun();
        do_reset();
        irq_en = 1'b1;
        do_sync();
        send_byte(8'h10); send_byte(8'h20); send_byte(8'h30); send_byte(8'h40);
        check("R5 no ov yet", st_ov, 0);
        send_byte(8'h55);
        check("R4 level full", fifo_level, 4);
        check("R5 ov", {st_ov, st_cd, st_closed}, 3'b101);
        check("R5 evt irq", {rx_evt, irq}, 2'b11);
        send_byte(8'hEE);
        check("R6 hunt ignores", fifo_level, 4);
        pop_check("R4 entry0", 8'h10);
        pop_check("R4 entry1", 8'h20);
        pop_check("R4 entry2", 8'h30);
        pop_check("R4 entry3", 8'h55);
        do_sync();
        check("R10 status cleared", {st_ov, st_cd, st_closed}, 0);
        send_byte(8'h66);
        check("R6 resumes after sync", rd_data, 8'h66);
    endtask

    task automatic t_cd();
        do_reset();
        do_sync();
        send_byte(8'h77);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        carrier_ok = 1'b0;
        @(negedge clk);
        carrier_ok = 1'b1;
        check("R7 cd status", {st_ov, st_cd, st_closed}, 3'b011);
        check("R7 evt", rx_evt, 1);
        send_byte(8'h99);
        check("R7 partial dropped and hunt", fifo_level, 1);
        do_sync();
        check("R10 cleared", {st_cd, st_closed}, 0);
        check("R10 fifo kept", rd_data, 8'h77);
    endtask

    task automatic t_cd_prio();
        do_reset();
        do_sync();
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        ser_valid = 1'b1; ser_bit = 1'b1; carrier_ok = 1'b0;
        @(negedge clk);
        ser_valid = 1'b0; carrier_ok = 1'b1;
        check("R8 only cd", {st_ov, st_cd, st_closed}, 3'b011);
        check("R8 level", fifo_level, 4);
        pop_check("R8 e0", 8'h01); pop_check("R8 e1", 8'h02); pop_check("R8 e2", 8'h03);
        pop_check("R8 newest kept", 8'h04);
    endtask

    task automatic t_irq();
        do_reset();
        do_sync();
        carrier_ok = 1'b0; @(negedge clk); carrier_ok = 1'b1;
        check("R9 masked", {rx_evt, irq}, 2'b10);
        irq_en = 1'b1; #1;
        check("R9 unmasked", irq, 1);
        @(negedge clk); @(negedge clk);
        check("R9 sticky", rx_evt, 1);
        evt_clr = 1'b1; @(negedge clk); evt_clr = 1'b0;
        check("R9 cleared", {rx_evt, irq}, 0);
        do_sync();
        // Set and clear in the same cycle: set wins.
        carrier_ok = 1'b0; evt_clr = 1'b1; @(negedge clk);
        carrier_ok = 1'b1; evt_clr = 1'b0;
        check("R9 set beats clear", rx_evt, 1);
    endtask

    initial begin
        t_reset();
        t_hunt();
        t_order();
        t_xfer();
        t_overrun();
        t_cd();
        t_cd_prio();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule